// File: doc/BRIEF.md
# Integer ALU with Barrel Shifter

This block is the purely combinational execute unit for the register-register operations of a 32-bit load/store RISC core. It takes two operands, a shift-amount field and a 6-bit function code. In the same evaluation it produces a result word, a signed-overflow flag and an invalid-code flag.

The operations fall into four groups:
- Arithmetic: add and subtract, each in a trapping and a non-trapping form.
- Compares: signed and unsigned less-than compares that return 0 or 1.
- Logic: four bitwise operations.
- Shifts: left, logical right and arithmetic right. Each shift takes its amount either from the instruction's shift field or from the low bits of the first operand.

The decode stage supplies the operands and the function code. The overflow flag feeds the core's trap logic. The invalid flag feeds its reserved-instruction handling. Immediate extension, operand forwarding and writeback are done outside this block.

Top module: `alu_core`

## Requirements
- R1: Code 0x20 and code 0x21 both return (a + b) mod 2^32.
- R2: Code 0x22 and code 0x23 both return (a - b) mod 2^32.
- R3: The overflow output is 1 only for codes 0x20 and 0x22, and only when the true signed result lies outside the 32-bit two's-complement range. For codes 0x21 and 0x23, and for every other code, it is 0.
- R4: Code 0x2A returns 1 when a < b as signed two's-complement values and returns 0 otherwise.
- R5: Code 0x2B returns 1 when a < b as unsigned values and returns 0 otherwise.
- R6: The logic codes are:
  - 0x24 returns a AND b.
  - 0x25 returns a OR b.
  - 0x26 returns a XOR b.
  - 0x27 returns NOT (a OR b).
- R7: Codes 0x00, 0x02 and 0x03 shift b left, logically right and arithmetically right, respectively. The amount is the 5-bit shift field.
- R8: Codes 0x04, 0x06 and 0x07 shift b left, logically right and arithmetically right, respectively. The amount is bits [4:0] of a. Bits [31:5] of a and the shift field have no effect on these codes.
- R9: A logical right shift fills vacated bits with 0. An arithmetic right shift fills them with b[31]. A left shift fills with 0.
- R10: Any code not listed in R1 to R8 returns a result of 0 with invalid at 1 and overflow at 0. Every listed code drives invalid to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First operand; also the variable shift amount source |
| b_i | input | 32 | Second operand; the value that shifts operate on |
| shamt_i | input | 5 | Shift amount from the instruction field |
| func_i | input | 6 | Function code |
| result_o | output | 32 | Operation result |
| ovf_o | output | 1 | Signed overflow of the trapping add or subtract |
| invalid_o | output | 1 | Function code not supported |

## Verification
Two outputs can respond to the same input combination.

The wrapped sum or difference and the overflow flag change together when a trapping add or subtract crosses the signed range. The bench provokes this by pairing edge operands such as 0x7FFFFFFF with 1 and 0x80000000 with 0xFFFFFFFF. For each such case it judges the result word and the flag against one arithmetic model.

Likewise, the invalid flag and the forced-zero result must agree on every unused code. The bench sweeps all 64 codes against every edge operand pair so that each unused code appears with operands that would produce nonzero results elsewhere.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned FUNC_W = 6;

  localparam logic [FUNC_W-1:0] FN_SLL  = 6'h00;
  localparam logic [FUNC_W-1:0] FN_SRL  = 6'h02;
  localparam logic [FUNC_W-1:0] FN_SRA  = 6'h03;
  localparam logic [FUNC_W-1:0] FN_SLLV = 6'h04;
  localparam logic [FUNC_W-1:0] FN_SRLV = 6'h06;
  localparam logic [FUNC_W-1:0] FN_SRAV = 6'h07;
  localparam logic [FUNC_W-1:0] FN_ADD  = 6'h20;
  localparam logic [FUNC_W-1:0] FN_ADDU = 6'h21;
  localparam logic [FUNC_W-1:0] FN_SUB  = 6'h22;
  localparam logic [FUNC_W-1:0] FN_SUBU = 6'h23;
  localparam logic [FUNC_W-1:0] FN_AND  = 6'h24;
  localparam logic [FUNC_W-1:0] FN_OR   = 6'h25;
  localparam logic [FUNC_W-1:0] FN_XOR  = 6'h26;
  localparam logic [FUNC_W-1:0] FN_NOR  = 6'h27;
  localparam logic [FUNC_W-1:0] FN_SLT  = 6'h2A;
  localparam logic [FUNC_W-1:0] FN_SLTU = 6'h2B;

  typedef enum logic [1:0] {
    LOG_AND = 2'b00,
    LOG_OR  = 2'b01,
    LOG_XOR = 2'b10,
    LOG_NOR = 2'b11
  } log_op_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             ovf_o,
  output logic             lt_s_o,
  output logic             lt_u_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_x;
  logic [WIDTH:0]   ext;

  assign b_x = sub_i ? ~b_i : b_i;
  assign ext = {1'b0, a_i} + {1'b0, b_x} + {{WIDTH{1'b0}}, sub_i};
  assign sum_o = ext[WIDTH-1:0];
  // operands agree in sign, result does not
  assign ovf_o  = (a_i[MSB] == b_x[MSB]) && (sum_o[MSB] != a_i[MSB]);
  // meaningful only when sub_i is set
  assign lt_s_o = sum_o[MSB] ^ ovf_o;
  assign lt_u_o = ~ext[WIDTH];
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0]      a_i,
  input  logic [WIDTH-1:0]      b_i,
  input  alu_pkg::log_op_e      op_i,
  output logic [WIDTH-1:0]      res_o
);
  always_comb begin
    unique case (op_i)
      alu_pkg::LOG_AND: res_o = a_i & b_i;
      alu_pkg::LOG_OR:  res_o = a_i | b_i;
      alu_pkg::LOG_XOR: res_o = a_i ^ b_i;
      default:          res_o = ~(a_i | b_i);
    endcase
  end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned SHW  = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [SHW-1:0]   amt_i,
  input  logic             left_i,
  input  logic             arith_i,
  output logic [WIDTH-1:0] res_o
);
  logic             fill;
  logic [WIDTH-1:0] stage [SHW+1];

  assign fill     = arith_i & data_i[WIDTH-1];
  assign stage[0] = data_i;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int unsigned S = 1 << k;
    logic [WIDTH-1:0] moved;
    assign moved = left_i ? {stage[k][WIDTH-1-S:0], {S{1'b0}}}
                          : {{S{fill}}, stage[k][WIDTH-1:S]};
    assign stage[k+1] = amt_i[k] ? moved : stage[k];
  end

  assign res_o = stage[SHW];
endmodule

// File: rtl/alu_core.sv
module alu_core #(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned SHW  = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0]           a_i,
  input  logic [WIDTH-1:0]           b_i,
  input  logic [SHW-1:0]             shamt_i,
  input  logic [alu_pkg::FUNC_W-1:0] func_i,
  output logic [WIDTH-1:0]           result_o,
  output logic                       ovf_o,
  output logic                       invalid_o
);
  import alu_pkg::*;

  logic             sub_sel;
  logic [WIDTH-1:0] as_sum, log_res, sh_res;
  logic             as_ovf, lt_s, lt_u;
  logic [SHW-1:0]   sh_amt;

  assign sub_sel = (func_i == FN_SUB) || (func_i == FN_SUBU) ||
                   (func_i == FN_SLT) || (func_i == FN_SLTU);
  // bit 2 picks the register amount
  assign sh_amt  = func_i[2] ? a_i[SHW-1:0] : shamt_i;

  alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a_i   (a_i),
    .b_i   (b_i),
    .sub_i (sub_sel),
    .sum_o (as_sum),
    .ovf_o (as_ovf),
    .lt_s_o(lt_s),
    .lt_u_o(lt_u)
  );

  alu_logic #(.WIDTH(WIDTH)) u_logic (
    .a_i  (a_i),
    .b_i  (b_i),
    .op_i (log_op_e'(func_i[1:0])),
    .res_o(log_res)
  );

  // bit 1 clear: left; bit 0 set: arithmetic
  alu_shifter #(.WIDTH(WIDTH)) u_shift (
    .data_i (b_i),
    .amt_i  (sh_amt),
    .left_i (~func_i[1]),
    .arith_i(func_i[0]),
    .res_o  (sh_res)
  );

  always_comb begin
    result_o  = '0;
    ovf_o     = 1'b0;
    invalid_o = 1'b0;
    unique case (func_i)
      FN_ADD, FN_SUB: begin
        result_o = as_sum;
        ovf_o    = as_ovf;
      end
      FN_ADDU, FN_SUBU:                 result_o = as_sum;
      FN_SLT:                           result_o = {{(WIDTH-1){1'b0}}, lt_s};
      FN_SLTU:                          result_o = {{(WIDTH-1){1'b0}}, lt_u};
      FN_AND, FN_OR, FN_XOR, FN_NOR:    result_o = log_res;
      FN_SLL, FN_SRL, FN_SRA,
      FN_SLLV, FN_SRLV, FN_SRAV:        result_o = sh_res;
      default:                          invalid_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned SHW  = $clog2(WIDTH)
) (
  input logic [WIDTH-1:0]           a_i,
  input logic [WIDTH-1:0]           b_i,
  input logic [SHW-1:0]             shamt_i,
  input logic [alu_pkg::FUNC_W-1:0] func_i,
  input logic [WIDTH-1:0]           result_o,
  input logic                       ovf_o,
  input logic                       invalid_o
);
  import alu_pkg::*;

  logic is_cmp, is_fix_sh, is_var_sh;
  assign is_cmp    = (func_i == FN_SLT) || (func_i == FN_SLTU);
  assign is_fix_sh = (func_i == FN_SLL) || (func_i == FN_SRL) || (func_i == FN_SRA);
  assign is_var_sh = (func_i == FN_SLLV) || (func_i == FN_SRLV) || (func_i == FN_SRAV);

  always_comb begin
    // R10
    a_r10_invalid_zero: assert (!invalid_o || (result_o == '0 && !ovf_o))
      else $error("invalid code gave nonzero result or overflow");
    // R3
    a_r3_ovf_trap_only: assert (!ovf_o || func_i == FN_ADD || func_i == FN_SUB)
      else $error("overflow on non-trapping code");
    // R4 R5
    a_r4_cmp_boolean: assert (!is_cmp || result_o[WIDTH-1:1] == '0)
      else $error("compare result not 0/1");
    // R7
    a_r7_zero_shift_id: assert (!(is_fix_sh && shamt_i == '0) || result_o == b_i)
      else $error("zero fixed shift changed value");
    // R8
    a_r8_zero_vshift_id: assert (!(is_var_sh && a_i[SHW-1:0] == '0) || result_o == b_i)
      else $error("zero variable shift changed value");
    // R10
    a_r10_valid_flag: assert (invalid_o == !(is_cmp || is_fix_sh || is_var_sh ||
                                             func_i[5:3] == 3'b100))
      else $error("invalid flag disagrees with code");
  end
endmodule

bind alu_core alu_core_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i      (a_i),
  .b_i      (b_i),
  .shamt_i  (shamt_i),
  .func_i   (func_i),
  .result_o (result_o),
  .ovf_o    (ovf_o),
  .invalid_o(invalid_o)
);

// File: tb/alu_core_tb.sv
module alu_core_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] a, b, res;
  logic [4:0]  shamt;
  logic [5:0]  func;
  logic        ovf, inv;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  alu_core u_dut (
    .a_i(a), .b_i(b), .shamt_i(shamt), .func_i(func),
    .result_o(res), .ovf_o(ovf), .invalid_o(inv)
  );

  function automatic string req_of(input logic [5:0] f);
    case (f)
      6'h20, 6'h21: return "R1";
      6'h22, 6'h23: return "R2";
      6'h2A:        return "R4";
      6'h2B:        return "R5";
      6'h24, 6'h25, 6'h26, 6'h27: return "R6";
      6'h00:        return "R7";
      6'h02, 6'h03: return "R7/R9";
      6'h04:        return "R8";
      6'h06, 6'h07: return "R8/R9";
      default:      return "R10";
    endcase
  endfunction

  task automatic ref_model(input logic [31:0] x, input logic [31:0] y,
                           input logic [4:0] sa, input logic [5:0] f,
                           output logic [31:0] r, output logic o, output logic iv);
    logic signed [32:0] wide;
    r = 32'd0; o = 1'b0; iv = 1'b0;
    case (f)
      6'h20: begin wide = $signed({x[31], x}) + $signed({y[31], y});
               r = x + y; o = (wide > 33'sd2147483647) || (wide < -33'sd2147483648); end
      6'h21: r = x + y;
      6'h22: begin wide = $signed({x[31], x}) - $signed({y[31], y});
               r = x - y; o = (wide > 33'sd2147483647) || (wide < -33'sd2147483648); end
      6'h23: r = x - y;
      6'h2A: r = ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      6'h2B: r = (x < y) ? 32'd1 : 32'd0;
      6'h24: r = x & y;
      6'h25: r = x | y;
      6'h26: r = x ^ y;
      6'h27: r = ~(x | y);
      6'h00: r = y << sa;
      6'h02: r = y >> sa;
      6'h03: r = $unsigned($signed(y) >>> sa);
      6'h04: r = y << x[4:0];
      6'h06: r = y >> x[4:0];
      6'h07: r = $unsigned($signed(y) >>> x[4:0]);
      default: iv = 1'b1;
    endcase
  endtask

  task automatic run(input logic [31:0] x, input logic [31:0] y,
                     input logic [4:0] sa, input logic [5:0] f);
    logic [31:0] er; logic eo, ei;
    @(negedge clk);
    a = x; b = y; shamt = sa; func = f;
    #1;
    ref_model(x, y, sa, f, er, eo, ei);
    n_chk++;
    if (res !== er) begin
      n_err++;
      $display("FAIL %s f=%h a=%h b=%h sa=%0d result actual=%h expected=%h",
               req_of(f), f, x, y, sa, res, er);
    end
    n_chk++;
    if (ovf !== eo) begin
      n_err++;
      $display("FAIL R3 f=%h a=%h b=%h ovf actual=%b expected=%b", f, x, y, ovf, eo);
    end
    n_chk++;
    if (inv !== ei) begin
      n_err++;
      $display("FAIL R10 f=%h invalid actual=%b expected=%b", f, inv, ei);
    end
  endtask

  logic [31:0] edges [8] = '{32'h0, 32'h1, 32'h7FFFFFFF, 32'h80000000,
                             32'hFFFFFFFF, 32'h12345678, 32'hDEADBEE3, 32'h0000001F};
  logic [4:0]  amts [4] = '{5'd0, 5'd1, 5'd17, 5'd31};

  initial begin
    a = '0; b = '0; shamt = '0; func = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // idle inputs: sll of zero gives zero, no flags (R7)
    run(32'h0, 32'h0, 5'd0, 6'h00);
    // R3 boundary cases
    run(32'h7FFFFFFF, 32'h1, 5'd0, 6'h20);
    run(32'h80000000, 32'hFFFFFFFF, 5'd0, 6'h20);
    run(32'h80000000, 32'h1, 5'd0, 6'h22);
    run(32'h7FFFFFFF, 32'hFFFFFFFF, 5'd0, 6'h22);
    run(32'h7FFFFFFF, 32'h1, 5'd0, 6'h21);
    run(32'h80000000, 32'h1, 5'd0, 6'h23);
    // R8: upper bits of a ignored, shift field ignored
    run(32'hFFFFFFE3, 32'h80000000, 5'd9, 6'h07);
    run(32'hABCDEF04, 32'h0000F00F, 5'd31, 6'h04);
    // R9 fills
    run(32'h0, 32'h80000000, 5'd31, 6'h03);
    run(32'h0, 32'h80000000, 5'd31, 6'h02);
    // sweep all codes over edge operands and amounts (R1..R10)
    for (int f = 0; f < 64; f++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          for (int k = 0; k < 4; k++)
            run(edges[i], edges[j], amts[k], 6'(f));
    // random operands over all codes
    for (int n = 0; n < 3000; n++)
      run($urandom, $urandom, 5'($urandom), 6'($urandom));
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule